// File: doc/BRIEF.md
# Two-Digit Decimal Rate Divider

This block counts enabled clock cycles in decimal. It is built from two identical decade stages, and each digit is held as a BCD value. The low stage advances on every cycle in which the count enable is high. The high stage advances only on the edge where the low stage wraps from nine back to zero. The carry between stages is an enable, so both stages share the one clock and update on the same edge. No stage clocks another.

Two divided outputs come from the stage terminal counts. The first is a one-cycle pulse for every ten enabled cycles. The second is a one-cycle pulse for every hundred. A synchronous, active-high reset returns both digits to zero. Typical uses are as a prescaler for slower logic, or as a decimal event tally whose digits other logic reads directly.

Top module: `dcd_div100`

## Requirements
- R1: On a clock edge with `rst` high, both digits become 0. After that edge, both divided outputs read 0.
- R2: On each edge with `cnt_en` high and `rst` low, `digit_lo` steps 0,1,...,9 and then returns to 0.
- R3: On an edge with `cnt_en` low, both digits keep their values. In that cycle both divided outputs are 0.
- R4: `div10_o` is 1 exactly in the cycles where `cnt_en` is 1 and `digit_lo` is 9. It is combinational, so it is valid in the same cycle and before the edge.
- R5: `digit_hi` rises by one on the same edge on which `digit_lo` wraps from 9 to 0. It keeps its value on every other edge.
- R6: `digit_hi` wraps from 9 to 0. The pair (`digit_hi`, `digit_lo`) therefore runs through 00..99 and repeats every 100 enabled cycles.
- R7: `div100_o` is 1 exactly in the cycles where `cnt_en` is 1, `digit_lo` is 9 and `digit_hi` is 9. After that edge both digits read 0.
- R8: Neither digit ever holds a value above 9.
- R9: When `rst` and `cnt_en` are both high on the same edge, the reset wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable for the low stage (the input count rate) |
| digit_lo | output | 4 | Units digit, BCD value 0..9 |
| digit_hi | output | 4 | Tens digit, BCD value 0..9 |
| div10_o | output | 1 | Low-stage terminal count: one pulse per ten enabled cycles |
| div100_o | output | 1 | Chain terminal count: one pulse per hundred enabled cycles |

## Verification
The bench builds the block with the default digit modulus of ten, so the whole 100-state cycle can be reached in a few hundred clocks. This covers both wraps of the high digit and the 99-to-00 transition, where both terminal counts are high together. The 99 state is also held with the enable low, which checks that the hold suppresses both pulses. A reset is applied mid-count with the enable still high.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Default modulus of one decimal stage
    localparam int unsigned DIGIT_MOD_DEF = 10;

    // Number of chained stages in the divider
    localparam int unsigned STAGE_CNT = 2;

    // Operation chosen for a stage on the coming edge
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_STEP  = 2'd1,
        OP_HOLD  = 2'd2
    } stage_op_e;

    // Per-stage handoff signals
    typedef struct packed {
        logic cen;   // enable arriving at the stage
        logic tc;    // terminal count leaving the stage
    } link_t;

    // Successor of a digit value with wrap at the modulus
    function automatic int unsigned wrap_next(input int unsigned v, input int unsigned m);
        return (v >= m - 1) ? 0 : v + 1;
    endfunction

    // Operation selection: reset first, then enable
    function automatic stage_op_e pick_op(input logic clr, input logic en);
        if (clr)
            return OP_CLEAR;
        else if (en)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/dcd_decade_stage.sv
module dcd_decade_stage
    import dcd_pkg::*;
#(
    parameter  int unsigned MOD = DIGIT_MOD_DEF,
    localparam int unsigned W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cen,
    output logic [W-1:0] cnt_o,
    output logic         tc_o
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;
    stage_op_e    op;

    always_comb begin
        op     = pick_op(rst, cen);
        cnt_nx = W'(wrap_next(32'(cnt_q), MOD));
    end

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: cnt_q <= '0;
            OP_STEP:  cnt_q <= cnt_nx;
            default:  cnt_q <= cnt_q;
        endcase
    end

    // Terminal count: last state while enabled, so the next stage steps on this edge
    assign tc_o  = cen & (cnt_q == LAST);
    assign cnt_o = cnt_q;

endmodule

// File: rtl/dcd_div100.sv
module dcd_div100
    import dcd_pkg::*;
#(
    parameter  int unsigned DIGIT_MOD = DIGIT_MOD_DEF,
    localparam int unsigned W         = $clog2(DIGIT_MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    output logic [W-1:0] digit_lo,
    output logic [W-1:0] digit_hi,
    output logic         div10_o,
    output logic         div100_o
);

    localparam int unsigned N = STAGE_CNT;

    link_t        link [N];
    logic [W-1:0] dig  [N];
    logic [N-1:0] tc_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign link[g].cen = cnt_en;
            end else begin : g_tail
                assign link[g].cen = link[g-1].tc;
            end

            dcd_decade_stage #(.MOD(DIGIT_MOD)) u_stage (
                .clk   (clk),
                .rst   (rst),
                .cen   (link[g].cen),
                .cnt_o (dig[g]),
                .tc_o  (link[g].tc)
            );

            assign tc_vec[g] = link[g].tc;
        end
    endgenerate

    assign digit_lo = dig[0];
    assign digit_hi = dig[N-1];
    assign div10_o  = tc_vec[0];
    assign div100_o = &tc_vec;

endmodule

// File: rtl/dcd_div100_chk.sv
module dcd_div100_chk #(
    parameter  int unsigned DIGIT_MOD = 10,
    localparam int unsigned W         = $clog2(DIGIT_MOD)
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic [W-1:0] digit_lo,
    input logic [W-1:0] digit_hi,
    input logic         div10_o,
    input logic         div100_o
);

    localparam logic [W-1:0] LAST = W'(DIGIT_MOD - 1);

    // R1 R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (digit_lo == '0) && (digit_hi == '0));

    // R2
    lo_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && digit_lo != LAST) |=> digit_lo == W'($past(digit_lo) + 1'b1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(digit_lo) && $stable(digit_hi));

    // R3
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> !div10_o && !div100_o);

    // R4
    lo_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        div10_o |=> digit_lo == '0);

    // R5
    hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (div10_o && digit_hi != LAST) |=> digit_hi == W'($past(digit_hi) + 1'b1));

    // R7
    full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        div100_o |=> (digit_lo == '0) && (digit_hi == '0));

    // R7
    nested_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div100_o |-> div10_o);

    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (digit_lo <= LAST) && (digit_hi <= LAST));

endmodule

bind dcd_div100 dcd_div100_chk #(.DIGIT_MOD(DIGIT_MOD)) u_chk (.*);

// File: tb/sim_dcd_div100.sv
`timescale 1ns/100ps
module sim_dcd_div100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] digit_lo;
    logic [3:0] digit_hi;
    logic       div10_o;
    logic       div100_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dcd_div100 u0 (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .digit_lo (digit_lo),
        .digit_hi (digit_hi),
        .div10_o  (div10_o),
        .div100_o (div100_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle: set enable, check pre-edge pulses, check digits after edge
    task automatic cyc(input logic en, input int e10, input int e100,
                       input int elo, input int ehi, input string req);
        @(negedge clk);
        cnt_en = en;
        #1;
        chk({req, " div10"},  int'(div10_o),  e10);
        chk({req, " div100"}, int'(div100_o), e100);
        @(posedge clk);
        #1;
        chk({req, " lo"}, int'(digit_lo), elo);
        chk({req, " hi"}, int'(digit_hi), ehi);
    endtask

    // {en, div10 before edge, lo after edge, hi after edge}, starting from 00
    localparam logic [9:0] VEC [14] = '{
        {1'b1, 1'b0, 4'd1, 4'd0},
        {1'b1, 1'b0, 4'd2, 4'd0},
        {1'b0, 1'b0, 4'd2, 4'd0},
        {1'b1, 1'b0, 4'd3, 4'd0},
        {1'b1, 1'b0, 4'd4, 4'd0},
        {1'b1, 1'b0, 4'd5, 4'd0},
        {1'b0, 1'b0, 4'd5, 4'd0},
        {1'b1, 1'b0, 4'd6, 4'd0},
        {1'b1, 1'b0, 4'd7, 4'd0},
        {1'b1, 1'b0, 4'd8, 4'd0},
        {1'b1, 1'b0, 4'd9, 4'd0},
        {1'b0, 1'b0, 4'd9, 4'd0},
        {1'b1, 1'b1, 4'd0, 4'd1},
        {1'b1, 1'b0, 4'd1, 4'd1}
    };

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 lo", int'(digit_lo), 0);
        chk("R1 hi", int'(digit_hi), 0);
        chk("R1 div10", int'(div10_o), 0);
        chk("R1 div100", int'(div100_o), 0);

        // Vector table: R2 stepping, R3 hold, R4 pulse, R5 carry
        for (int i = 0; i < 14; i++) begin
            cyc(VEC[i][9], int'(VEC[i][8]), 0, int'(VEC[i][7:4]), int'(VEC[i][3:0]),
                "R2 R3 R4 R5 table");
        end

        // Long run through two full hundreds: R6 wrap, R7 pulse, R8 range
        n = 11;
        for (int k = 0; k < 200; k++) begin
            cyc(1'b1, (n % 10 == 9) ? 1 : 0, (n % 100 == 99) ? 1 : 0,
                ((n + 1) % 10), (((n + 1) / 10) % 10), "R6 R7 R8 run");
            n = n + 1;
        end

        // Advance to 99
        for (int k = 0; k < 88; k++) begin
            cyc(1'b1, (n % 10 == 9) ? 1 : 0, (n % 100 == 99) ? 1 : 0,
                ((n + 1) % 10), (((n + 1) / 10) % 10), "R6 approach");
            n = n + 1;
        end
        // R3: hold at 99 with enable low, no pulses
        cyc(1'b0, 0, 0, 9, 9, "R3 hold99");
        cyc(1'b0, 0, 0, 9, 9, "R3 hold99b");
        // R7: 99 -> 00 with both pulses
        cyc(1'b1, 1, 1, 0, 0, "R7 wrap99");

        // R9: reset beats enable mid-count
        cyc(1'b1, 0, 0, 1, 0, "R9 pre");
        cyc(1'b1, 0, 0, 2, 0, "R9 pre");
        @(negedge clk);
        rst = 1'b1;
        cnt_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 lo", int'(digit_lo), 0);
        chk("R9 hi", int'(digit_hi), 0);
        @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b0;
        #1;
        chk("R1 div10 after reset", int'(div10_o), 0);
        chk("R1 div100 after reset", int'(div100_o), 0);
        cyc(1'b1, 0, 0, 1, 0, "R2 restart");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule